// File: doc/BRIEF.md
# Sampling strobe and data-burst window generator

This block drives the two timing lines that a fast serial-output converter needs in a capture path. The first line is a conversion strobe. Its rising edge starts sampling, and it stays high for a programmed number of reference-clock cycles. The second line is a gate window that lets the reference clock through to the converter for exactly one data word per sample. All timing is counted in reference-clock cycles. Both lines share one period. The window opens a programmed delay after each conversion edge and stays open for as many cycles as the word has bits.

Settings are presented on plain inputs and captured together when a start request is accepted, so a running period never mixes old and new values. Start and stop follow a fixed order. The strobe runs alone for its first period, and the window is brought in only after that, at the period boundary. A stop closes the window at once and lets the strobe finish its current period. Settings that cannot produce a legal waveform are refused and raise an error flag. The strobe is validated at start. The window is validated at the end of the first period, and a refusal there also shuts the strobe off.

Top module: `adc_strobe_gen`

## Requirements
- R1: While reset is asserted, and until the first accepted start, `cnv_o`, `gate_o` and `cfg_err_o` are low.
- R2: The captured period equals `req_period_i` clamped to the range [MIN_PER, MAX_PER] cycles. With the defaults (10 and 1000), a request of 3 gives 10 and a request of 5000 gives 1000. Conversion rising edges repeat at that spacing.
- R3: A start request in the idle state is sampled on a rising clock edge. The period counter then runs 0 .. period-1 from that edge. `cnv_o` is high exactly while the counter is below the captured conversion-high count.
- R4: While the window is enabled, `gate_o` is high exactly while the counter lies in [delay, delay + bits). In each period this gives `data_bits_i` consecutive cycles that begin `msb_delay_i` cycles after the conversion edge.
- R5: `gate_o` stays low for the whole first period after a start. It is enabled from the second period on.
- R6: A start with a conversion-high count of 0, or not below the clamped period, is refused. The block stays idle with both outputs low, and `cfg_err_o` goes high on the next edge.
- R7: If the captured delay is not below the period, or the bit count is 0, or delay + bits exceeds the period, the strobe runs one period with no window. It is then switched off and `cfg_err_o` is set.
- R8: A stop request closes the window from the next cycle. The strobe finishes the period it is in and then stays low.
- R9: Start requests and setting changes made while the block is running have no effect on the outputs.
- R10: An accepted start clears `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only when idle |
| stop_i | input | 1 | Stop request |
| req_period_i | input | REQ_W | Requested sample period in cycles |
| conv_high_i | input | CNT_W | Conversion strobe high time in cycles |
| msb_delay_i | input | CNT_W | Window offset from the conversion edge in cycles |
| data_bits_i | input | NB_W | Bits per word, which is the window length in cycles |
| cnv_o | output | 1 | Conversion strobe |
| gate_o | output | 1 | Clock-gate window |
| cfg_err_o | output | 1 | Last start request was refused |

## Verification
The hardest cases to reach are the late refusal of the window settings and a stop that lands while the window is still waiting to be enabled. Both depend on where the counter is in the first period, not on the inputs alone. The bench starts the block with window settings that pass the strobe check but fail the window check. It then counts strobe cycles across that first period to confirm that one full pulse appears, followed by shutdown and the error flag. It also changes every setting input and pulses start in the middle of a run, and then measures edge spacing to show that the captured values are still in use. A reference model runs on every clock, so stops at arbitrary counter positions, including the wrap edge, are compared cycle by cycle.

// File: rtl/adc_strb_pkg.sv
package adc_strb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CNV   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } strb_state_e;
endpackage

// File: rtl/adc_strb_cfg.sv
module adc_strb_cfg #(
  parameter int MIN_PER = 10,
  parameter int MAX_PER = 1000,
  parameter int REQ_W   = 16,
  parameter int CNT_W   = 10,
  parameter int NB_W    = 5
) (
  input  logic [REQ_W-1:0] req_period_i,
  input  logic [CNT_W-1:0] conv_high_i,
  input  logic [CNT_W-1:0] msb_delay_i,
  input  logic [NB_W-1:0]  data_bits_i,
  output logic [CNT_W-1:0] period_o,
  output logic             cnv_ok_o,
  output logic             gate_ok_o
);
  localparam int SUM_W = ((CNT_W > NB_W) ? CNT_W : NB_W) + 1;
  localparam logic [REQ_W-1:0] MIN_R = REQ_W'(MIN_PER);
  localparam logic [REQ_W-1:0] MAX_R = REQ_W'(MAX_PER);

  logic [REQ_W-1:0] per_r;
  logic [SUM_W-1:0] end_s, per_s;

  always_comb begin
    if (req_period_i < MIN_R)      per_r = MIN_R;
    else if (req_period_i > MAX_R) per_r = MAX_R;
    else                           per_r = req_period_i;
  end

  assign period_o = CNT_W'(per_r);
  assign per_s    = SUM_W'(period_o);
  assign end_s    = SUM_W'(msb_delay_i) + SUM_W'(data_bits_i);

  assign cnv_ok_o  = (conv_high_i != '0) && (conv_high_i < period_o);
  assign gate_ok_o = (data_bits_i != '0) && (msb_delay_i < period_o) && (end_s <= per_s);
endmodule

// File: rtl/adc_strb_tmr.sv
module adc_strb_tmr #(
  parameter int CNT_W = 10,
  parameter int NB_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] conv_high_i,
  input  logic [CNT_W-1:0] msb_delay_i,
  input  logic [NB_W-1:0]  data_bits_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             cnv_win_o,
  output logic             gate_win_o
);
  localparam int SUM_W = ((CNT_W > NB_W) ? CNT_W : NB_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] cnt_s, end_s;

  assign wrap_o = en_i && (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_s      = SUM_W'(cnt_q);
  assign end_s      = SUM_W'(msb_delay_i) + SUM_W'(data_bits_i);
  assign cnv_win_o  = en_i && (cnt_q < conv_high_i);
  assign gate_win_o = en_i && (cnt_q >= msb_delay_i) && (cnt_s < end_s);
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/adc_strb_seq.sv
module adc_strb_seq
  import adc_strb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        cnv_ok_i,
  input  logic        gate_ok_i,
  input  logic        wrap_i,
  output strb_state_e state_o,
  output logic        load_o,
  output logic        cnv_en_o,
  output logic        gate_en_o,
  output logic        err_o
);
  strb_state_e st_q, st_d;
  logic        err_q, err_d;

  always_comb begin
    st_d   = st_q;
    err_d  = err_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          err_d = !cnv_ok_i;
          if (cnv_ok_i) begin
            load_o = 1'b1;
            st_d   = ST_CNV;
          end
        end
      end
      ST_CNV: begin
        if (stop_i) st_d = wrap_i ? ST_IDLE : ST_DRAIN;
        else if (wrap_i) begin
          if (gate_ok_i) st_d = ST_RUN;
          else begin
            st_d  = ST_IDLE;
            err_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (stop_i) st_d = wrap_i ? ST_IDLE : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (wrap_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign state_o   = st_q;
  assign cnv_en_o  = (st_q != ST_IDLE);
  assign gate_en_o = (st_q == ST_RUN);
  assign err_o     = err_q;
endmodule

// File: rtl/adc_strobe_gen.sv
module adc_strobe_gen
  import adc_strb_pkg::*;
#(
  parameter int MIN_PER = 10,
  parameter int MAX_PER = 1000,
  parameter int REQ_W   = 16,
  parameter int CNT_W   = $clog2(MAX_PER + 1),
  parameter int NB_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REQ_W-1:0] req_period_i,
  input  logic [CNT_W-1:0] conv_high_i,
  input  logic [CNT_W-1:0] msb_delay_i,
  input  logic [NB_W-1:0]  data_bits_i,
  output logic             cnv_o,
  output logic             gate_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] per_d, per_q, hi_q, dly_q, cnt;
  logic [NB_W-1:0]  nb_q;
  logic             cnv_ok, gate_ok, gate_ok_q;
  logic             load, cnv_en, gate_en, wrap, cnv_win, gate_win;
  strb_state_e      state;

  adc_strb_cfg #(
    .MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .REQ_W(REQ_W), .CNT_W(CNT_W), .NB_W(NB_W)
  ) i_cfg (
    .req_period_i(req_period_i),
    .conv_high_i (conv_high_i),
    .msb_delay_i (msb_delay_i),
    .data_bits_i (data_bits_i),
    .period_o    (per_d),
    .cnv_ok_o    (cnv_ok),
    .gate_ok_o   (gate_ok)
  );

  // settings captured together on an accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q     <= CNT_W'(MIN_PER);
      hi_q      <= '0;
      dly_q     <= '0;
      nb_q      <= '0;
      gate_ok_q <= 1'b0;
    end else if (load) begin
      per_q     <= per_d;
      hi_q      <= conv_high_i;
      dly_q     <= msb_delay_i;
      nb_q      <= data_bits_i;
      gate_ok_q <= gate_ok;
    end
  end

  adc_strb_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .cnv_ok_i (cnv_ok),
    .gate_ok_i(gate_ok_q),
    .wrap_i   (wrap),
    .state_o  (state),
    .load_o   (load),
    .cnv_en_o (cnv_en),
    .gate_en_o(gate_en),
    .err_o    (cfg_err_o)
  );

  adc_strb_tmr #(.CNT_W(CNT_W), .NB_W(NB_W)) i_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cnv_en),
    .period_i   (per_q),
    .conv_high_i(hi_q),
    .msb_delay_i(dly_q),
    .data_bits_i(nb_q),
    .cnt_o      (cnt),
    .wrap_o     (wrap),
    .cnv_win_o  (cnv_win),
    .gate_win_o (gate_win)
  );

  assign cnv_o  = cnv_win;
  assign gate_o = gate_win && gate_en;
endmodule

// File: rtl/adc_strobe_gen_chk.sv
module adc_strobe_gen_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic             cnv_o,
  input logic             gate_o,
  input logic             cfg_err_o,
  input logic             cnv_en,
  input logic             gate_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] dly_q
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!cnv_o && !gate_o && !cfg_err_o)); // R1

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_en |-> (cnt < per_q)); // R3

  AST_CNV_RISE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> (cnt == '0)); // R3

  AST_GATE_RISE_AT_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> (cnt == dly_q)); // R4

  AST_GATE_NEEDS_CNV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en |-> cnv_en); // R8

  AST_STOP_CLOSES_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !gate_o); // R8

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!cnv_o && !gate_o)); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_en && $past(cnv_en)) |-> ($stable(per_q) && $stable(dly_q))); // R9
endmodule

bind adc_strobe_gen adc_strobe_gen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stop_i   (stop_i),
  .cnv_o    (cnv_o),
  .gate_o   (gate_o),
  .cfg_err_o(cfg_err_o),
  .cnv_en   (cnv_en),
  .gate_en  (gate_en),
  .cnt      (cnt),
  .per_q    (per_q),
  .dly_q    (dly_q)
);

// File: tb/test_adc_strobe_gen.sv
module test_adc_strobe_gen;
  localparam int MIN_PER = 10;
  localparam int MAX_PER = 1000;
  localparam int REQ_W   = 16;
  localparam int CNT_W   = $clog2(MAX_PER + 1);
  localparam int NB_W    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0, stop = 1'b0;
  logic [REQ_W-1:0] req = '0;
  logic [CNT_W-1:0] hi = '0, dly = '0;
  logic [NB_W-1:0]  nb = '0;
  logic             cnv, gate, err;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk; // 50 MHz

  adc_strobe_gen #(
    .MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .REQ_W(REQ_W), .CNT_W(CNT_W), .NB_W(NB_W)
  ) i_adc_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .req_period_i(req), .conv_high_i(hi), .msb_delay_i(dly), .data_bits_i(nb),
    .cnv_o(cnv), .gate_o(gate), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  // behavioural reference model: 0 idle, 1 strobe only, 2 both, 3 draining
  int m_st = 0, m_cnt = 0, m_per = MIN_PER, m_hi = 0, m_dly = 0, m_nb = 0;
  bit m_err = 1'b0;

  function automatic int clampv(int v);
    if (v < MIN_PER) return MIN_PER;
    if (v > MAX_PER) return MAX_PER;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_err = 1'b0;
    end else if (m_st == 0) begin
      if (start) begin
        int p;
        p = clampv(int'(req));
        if (hi == 0 || int'(hi) >= p) m_err = 1'b1;
        else begin
          m_err = 1'b0; m_st = 1; m_cnt = 0;
          m_per = p; m_hi = int'(hi); m_dly = int'(dly); m_nb = int'(nb);
        end
      end
    end else begin
      bit w;
      w = (m_cnt == m_per - 1);
      if (m_st == 3) begin
        if (w) m_st = 0;
      end else if (stop) m_st = w ? 0 : 3;
      else if (m_st == 1 && w) begin
        if (m_nb == 0 || m_dly >= m_per || m_dly + m_nb > m_per) begin
          m_st = 0; m_err = 1'b1;
        end else m_st = 2;
      end
      m_cnt = (w || m_st == 0) ? 0 : m_cnt + 1;
    end
  end

  // per-cycle comparison and edge-spacing measurement
  bit prev_cnv = 1'b0, have_rise = 1'b0;
  int last_rise = 0, last_iv = 0;

  always @(negedge clk) begin
    bit e_cnv, e_gate;
    cyc++;
    if (rst_n) begin
      e_cnv  = (m_st != 0) && (m_cnt < m_hi);
      e_gate = (m_st == 2) && (m_cnt >= m_dly) && (m_cnt < m_dly + m_nb);
      chk(cnv == e_cnv, {cur_req, "/R3 cnv"}, int'(cnv), int'(e_cnv));
      chk(gate == e_gate, {cur_req, "/R4 gate"}, int'(gate), int'(e_gate));
      chk(err == m_err, {cur_req, "/R6 err"}, int'(err), int'(m_err));
      if (cnv && !prev_cnv) begin
        if (have_rise) last_iv = cyc - last_rise;
        last_rise = cyc;
        have_rise = 1'b1;
      end
    end
    prev_cnv = cnv;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic setup(input int p, input int h, input int d, input int b);
    req = REQ_W'(p); hi = CNT_W'(h); dly = CNT_W'(d); nb = NB_W'(b);
    have_rise = 1'b0; last_iv = 0;
  endtask

  task automatic count_high(input int n, output int c_cnv, output int c_gate);
    c_cnv = 0; c_gate = 0;
    for (int i = 0; i < n; i++) begin
      if (cnv) c_cnv++;
      if (gate) c_gate++;
      @(negedge clk);
    end
  endtask

  initial begin
    int cc, cg;
    wait_cyc(3);
    chk(!cnv && !gate && !err, "R1 reset", int'({cnv, gate, err}), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(!cnv && !gate && !err, "R1 idle", int'({cnv, gate, err}), 0);

    // nominal run
    cur_req = "R5";
    setup(20, 4, 7, 8);
    pulse_start();
    count_high(20, cc, cg);
    chk(cg == 0, "R5 first period gate", cg, 0);
    chk(cc == 4, "R3 first period cnv", cc, 4);
    count_high(20, cc, cg);
    chk(cg == 8, "R4 gate length", cg, 8);
    // R9: new settings and start while running have no effect
    cur_req = "R9";
    setup(50, 9, 2, 3);
    pulse_start();
    wait_cyc(70);
    chk(last_iv == 20, "R9 period kept", last_iv, 20);
    cur_req = "R8";
    pulse_stop();
    chk(!gate, "R8 gate closed", int'(gate), 0);
    wait_cyc(20);
    count_high(40, cc, cg);
    chk(cc == 0 && cg == 0, "R8 quiet after stop", cc + cg, 0);

    // R2 low clamp
    cur_req = "R2";
    setup(3, 2, 0, 10);
    pulse_start();
    wait_cyc(45);
    chk(last_iv == 10, "R2 low clamp", last_iv, 10);
    pulse_stop();
    wait_cyc(15);

    // R2 high clamp
    setup(5000, 8, 900, 18);
    pulse_start();
    wait_cyc(2100);
    chk(last_iv == 1000, "R2 high clamp", last_iv, 1000);
    pulse_stop();
    wait_cyc(1010);

    // R6 refusals
    cur_req = "R6";
    setup(20, 0, 2, 4);
    pulse_start();
    chk(err, "R6 zero high", int'(err), 1);
    count_high(30, cc, cg);
    chk(cc == 0 && cg == 0, "R6 idle after refusal", cc + cg, 0);
    setup(20, 20, 2, 4);
    pulse_start();
    chk(err, "R6 high not below period", int'(err), 1);

    // R10 accepted start clears flag
    cur_req = "R10";
    setup(16, 3, 1, 4);
    pulse_start();
    chk(!err, "R10 err cleared", int'(err), 0);
    wait_cyc(37);
    pulse_stop();
    wait_cyc(20);

    // R7 window refused after first period
    cur_req = "R7";
    setup(20, 4, 20, 8);
    pulse_start();
    count_high(20, cc, cg);
    chk(cc == 4, "R7 one strobe", cc, 4);
    chk(err, "R7 err set", int'(err), 1);
    count_high(40, cc, cg);
    chk(cc == 0 && cg == 0, "R7 shut off", cc + cg, 0);
    setup(20, 4, 3, 0);
    pulse_start();
    wait_cyc(20);
    chk(err, "R7 zero bits", int'(err), 1);
    setup(20, 4, 15, 8);
    pulse_start();
    wait_cyc(20);
    chk(err, "R7 window overrun", int'(err), 1);

    // stop exactly at the wrap edge and during first period
    cur_req = "R8";
    setup(12, 2, 4, 5);
    pulse_start();
    wait_cyc(10);
    pulse_stop();
    wait_cyc(30);
    pulse_start();
    wait_cyc(3);
    pulse_stop();
    wait_cyc(30);
    chk(!cnv && !gate, "R8 final idle", int'({cnv, gate}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule